// File: doc/BRIEF.md
# Echoed-Clock Serial Result Output Stage

This block models, in synthesizable form, the digital output side of a sampling converter that is read out by a host-supplied burst clock. A rising edge on the start input begins a conversion of fixed length. The conversion always runs to its end, and start edges that arrive while it is busy are discarded. When the ready delay expires, the block latches the 16-bit value presented on `sample_in` and puts its most significant bit on the serial data output. The host then bursts a clock into the block. The block sends that clock straight back on an echo output and advances the data on each falling echo edge, so the host captures one bit on every rising echo edge.

The conversion has two phases. In the first, the host may still finish reading the previous result. The second phase starts at the clock-low point and lasts until the new result is ready. During it, the data and echo outputs are both held at 0 and any leftover bits of the previous result are discarded. If bits were discarded, a lost-data flag is raised. The first result produced after reset carries an invalid marker. All timing is counted in cycles of the model clock `clk`, and the burst clock is sampled in that clock domain.

Top module: `eco_serial_out`

## Requirements
- R1: When the block is idle, a start input sampled at 1 after being sampled at 0 is accepted on that clock edge (E0). The new result's bit 15 appears on `data_out` right after edge E0+MSB_CYC, and `data_out` is 0 through the cycle before that edge.
- R2: A rising start edge that arrives while a conversion is running has no effect. The ready time stays at E0+MSB_CYC of the original accepted edge.
- R3: On the ready edge, `sample_in` is latched and its bit 15 is presented before any burst clock pulse. Successive bits follow from the most significant bit down to bit 0.
- R4: `echo_clk_out` equals `burst_clk_in` delayed by one model clock. `data_out` moves to the next bit in the same cycle that `echo_clk_out` falls, so the value seen at each rising echo edge is the current bit.
- R5: From the clock-low edge E0+CLKL_CYC until the ready edge, `data_out` and `echo_clk_out` are 0 whatever `burst_clk_in` does.
- R6: After all 16 bits have been shifted out, `data_out` is 0. Further burst pulses are still echoed but change nothing else.
- R7: `first_invalid_o` is 1 after reset and stays 1 for the first result. It is 0 from the second result's ready edge onward.
- R8: At each clock-low edge, `data_lost_o` is set to 1 if fewer than 16 bits of the previous result were clocked out, and to 0 otherwise. It holds that value until the next clock-low edge.
- R9: Reading of the previous result may continue after a new conversion starts, up to its clock-low edge, with correct bits and no loss flagged.
- R10: While reset (`rst_n` low) is applied, `data_out`, `echo_clk_out` and `data_lost_o` are 0 and `first_invalid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; all timing is counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_in | input | 1 | Convert request; a rising edge starts a conversion |
| sample_in | input | DATA_W | Value latched as the result at ready time |
| burst_clk_in | input | 1 | Host serial clock, idle low |
| data_out | output | 1 | Serial result, MSB first |
| echo_clk_out | output | 1 | Echo of the burst clock, in phase with the data |
| data_lost_o | output | 1 | Previous result not fully read by the clock-low point |
| first_invalid_o | output | 1 | Current result is the first one after reset |

## Verification
The bench places a second start edge in the middle of a conversion. A design that restarted its timer on that edge would still show 0 at the expected ready cycle. It also drives the burst clock high inside the quiet window, so a design without gating would leak an echo pulse there. One result is read only partially and another is read entirely after the next conversion has begun. A design that checked for loss at the wrong moment, or that dropped bits as soon as a conversion started, would get the lost flag or the scoreboard bits wrong. Extra pulses after the sixteenth bit must read back as zeros, and the invalid marker must clear exactly at the second ready edge.

// File: rtl/eco_pkg.sv
package eco_pkg;

    // Conversion timer phases
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,  // no conversion running
        PH_OPEN  = 2'd1,  // converting, previous result still readable
        PH_QUIET = 2'd2   // converting, outputs held at zero
    } eco_phase_e;

endpackage

// File: rtl/eco_conv_timer.sv
module eco_conv_timer
    import eco_pkg::*;
#(
    parameter int CLKL_CYC = 40,
    parameter int MSB_CYC  = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_in,
    output logic clkl_evt,
    output logic ready_evt,
    output logic quiet,
    output logic busy
);

    localparam int CNT_W = $clog2(MSB_CYC + 1);
    localparam logic [CNT_W-1:0] CLKL_LAST = CNT_W'(CLKL_CYC - 1);
    localparam logic [CNT_W-1:0] MSB_LAST  = CNT_W'(MSB_CYC - 1);

    typedef struct packed {
        eco_phase_e       phase;
        logic             start_prev;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t s_q, s_d;
    logic       rise;

    assign rise      = start_in & ~s_q.start_prev;
    assign clkl_evt  = (s_q.phase == PH_OPEN)  && (s_q.cnt == CLKL_LAST);
    assign ready_evt = (s_q.phase == PH_QUIET) && (s_q.cnt == MSB_LAST);
    assign quiet     = (s_q.phase == PH_QUIET);
    assign busy      = (s_q.phase != PH_IDLE);

    always_comb begin
        s_d            = s_q;
        s_d.start_prev = start_in;
        case (s_q.phase)
            PH_IDLE: begin
                if (rise) begin
                    s_d.phase = PH_OPEN;
                    s_d.cnt   = '0;
                end
            end
            PH_OPEN: begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (clkl_evt) begin
                    s_d.phase = PH_QUIET;
                end
            end
            PH_QUIET: begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (ready_evt) begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
                s_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase      <= PH_IDLE;
            s_q.start_prev <= 1'b0;
            s_q.cnt        <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rise) |=> (s_q.phase == PH_OPEN && s_q.cnt == '0));

    // R2
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ready_evt) |=> (busy && s_q.cnt == $past(s_q.cnt) + 1'b1));

    // R5
    quiet_after_clkl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clkl_evt |=> quiet);

    initial begin
        assert (CLKL_CYC >= 1 && CLKL_CYC < MSB_CYC)
            else $error("eco_conv_timer: need 1 <= CLKL_CYC < MSB_CYC");
    end

endmodule

// File: rtl/eco_shifter.sv
module eco_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              burst_clk_in,
    input  logic              clkl_evt,
    input  logic              ready_evt,
    input  logic              quiet,
    output logic              data_out,
    output logic              echo_clk_out,
    output logic              data_lost_o,
    output logic              first_invalid_o
);

    localparam int BC_W = $clog2(DATA_W + 1);
    localparam logic [BC_W-1:0] FULL = BC_W'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [BC_W-1:0]   left;
        logic              clk_prev;
        logic              lost;
        logic              invalid;
        logic              seen;
    } shf_state_t;

    shf_state_t s_q, s_d;
    logic       fall;
    logic       active;

    assign fall   = s_q.clk_prev & ~burst_clk_in;
    assign active = !quiet && (s_q.left != '0);

    assign data_out        = active & s_q.shreg[DATA_W-1];
    assign echo_clk_out    = s_q.clk_prev & ~quiet;
    assign data_lost_o     = s_q.lost;
    assign first_invalid_o = s_q.invalid;

    always_comb begin
        s_d          = s_q;
        s_d.clk_prev = burst_clk_in;
        if (ready_evt) begin
            s_d.shreg   = sample_in;
            s_d.left    = FULL;
            s_d.invalid = ~s_q.seen;
            s_d.seen    = 1'b1;
        end else if (clkl_evt) begin
            s_d.lost  = (s_q.left != '0);
            s_d.left  = '0;
            s_d.shreg = '0;
        end else if (fall && active) begin
            s_d.shreg = {s_q.shreg[DATA_W-2:0], 1'b0};
            s_d.left  = s_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.shreg    <= '0;
            s_q.left     <= '0;
            s_q.clk_prev <= 1'b0;
            s_q.lost     <= 1'b0;
            s_q.invalid  <= 1'b1;
            s_q.seen     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R5
    quiet_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> (s_q.left == '0));

    // R6
    left_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.left <= FULL);

    // R4
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && active && !ready_evt && !clkl_evt)
        |=> (s_q.left == $past(s_q.left) - 1'b1 && !echo_clk_out));

    // R8
    lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clkl_evt && s_q.left != '0) |=> data_lost_o);

    // R7
    invalid_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_evt && s_q.seen) |=> !first_invalid_o);

endmodule

// File: rtl/eco_serial_out.sv
module eco_serial_out
    import eco_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CLKL_CYC = 40,
    parameter int MSB_CYC  = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_in,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              burst_clk_in,
    output logic              data_out,
    output logic              echo_clk_out,
    output logic              data_lost_o,
    output logic              first_invalid_o
);

    logic clkl_evt;
    logic ready_evt;
    logic quiet;
    logic busy;

    eco_conv_timer #(
        .CLKL_CYC (CLKL_CYC),
        .MSB_CYC  (MSB_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_in  (start_in),
        .clkl_evt  (clkl_evt),
        .ready_evt (ready_evt),
        .quiet     (quiet),
        .busy      (busy)
    );

    eco_shifter #(
        .DATA_W (DATA_W)
    ) u_shifter (
        .clk             (clk),
        .rst_n           (rst_n),
        .sample_in       (sample_in),
        .burst_clk_in    (burst_clk_in),
        .clkl_evt        (clkl_evt),
        .ready_evt       (ready_evt),
        .quiet           (quiet),
        .data_out        (data_out),
        .echo_clk_out    (echo_clk_out),
        .data_lost_o     (data_lost_o),
        .first_invalid_o (first_invalid_o)
    );

    // R1
    ready_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_evt |-> (busy && quiet));

endmodule

// File: tb/eco_serial_out_bench.sv
module eco_serial_out_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 16;
    localparam int CLKL = 40;
    localparam int MSB  = 56;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_in = 1'b0;
    logic [DW-1:0] sample_in = '0;
    logic          burst_clk_in = 1'b0;
    logic          data_out, echo_clk_out, data_lost_o, first_invalid_o;

    eco_serial_out #(.DATA_W(DW), .CLKL_CYC(CLKL), .MSB_CYC(MSB)) u_eco_serial_out (
        .clk(clk), .rst_n(rst_n), .start_in(start_in), .sample_in(sample_in),
        .burst_clk_in(burst_clk_in), .data_out(data_out), .echo_clk_out(echo_clk_out),
        .data_lost_o(data_lost_o), .first_invalid_o(first_invalid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    logic  exp_q[$];
    string tag_q[$];
    logic  prev_echo = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: compare the bit present at every rising echo edge
    always @(negedge clk) begin
        if (rst_n && echo_clk_out && !prev_echo) begin
            if (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(data_out == e, t, "serial bit", int'(data_out), int'(e));
            end else begin
                check(1'b0, "R4", "unexpected echo edge", 1, 0);
            end
        end
        prev_echo = echo_clk_out;
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_start();
        start_in = 1'b1;
        tick(1);
        start_in = 1'b0;
    endtask

    // driver: push expected bits, then burst the clock
    task automatic read_bits(input logic [DW-1:0] v, input int first, input int n,
                             input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v[DW-1-first-i]);
            tag_q.push_back(tag);
        end
        for (int i = 0; i < n; i++) begin
            burst_clk_in = 1'b1;
            tick(1);
            check(echo_clk_out == 1'b1, "R4", "echo follows burst clock", int'(echo_clk_out), 1);
            burst_clk_in = 1'b0;
            tick(1);
        end
    endtask

    localparam logic [DW-1:0] VA = 16'hB5C3;
    localparam logic [DW-1:0] VB = 16'h9A17;
    localparam logic [DW-1:0] VC = 16'h6E29;
    localparam logic [DW-1:0] VD = 16'h3F81;
    localparam logic [DW-1:0] VE = 16'hC3A5;

    initial begin
        tick(3);
        // R10 reset state
        check(data_out == 1'b0, "R10", "data in reset", int'(data_out), 0);
        check(echo_clk_out == 1'b0, "R10", "echo in reset", int'(echo_clk_out), 0);
        check(data_lost_o == 1'b0, "R10", "lost in reset", int'(data_lost_o), 0);
        check(first_invalid_o == 1'b1, "R10", "invalid in reset", int'(first_invalid_o), 1);
        rst_n = 1'b1;
        tick(2);

        // R1 R3 R7: first conversion
        sample_in = VA;
        pulse_start();
        tick(MSB - 1);
        check(data_out == 1'b0, "R1", "data before ready", int'(data_out), 0);
        tick(1);
        check(data_out == VA[DW-1], "R1", "MSB at ready", int'(data_out), int'(VA[DW-1]));
        check(first_invalid_o == 1'b1, "R7", "first result marked", int'(first_invalid_o), 1);
        read_bits(VA, 0, DW, "R3");
        check(data_out == 1'b0, "R6", "data after last bit", int'(data_out), 0);
        for (int i = 0; i < 2; i++) begin
            exp_q.push_back(1'b0);
            tag_q.push_back("R6");
        end
        for (int i = 0; i < 2; i++) begin
            burst_clk_in = 1'b1; tick(1);
            burst_clk_in = 1'b0; tick(1);
        end

        // R2 R5 R7: extra start edge mid-conversion, clock inside quiet window
        sample_in = VB;
        pulse_start();
        for (int i = 1; i <= MSB - 1; i++) begin
            start_in = (i == 3);
            burst_clk_in = (i >= CLKL + 2 && i <= CLKL + 6);
            if (i == CLKL + 5) begin
                check(echo_clk_out == 1'b0, "R5", "echo in quiet window", int'(echo_clk_out), 0);
                check(data_out == 1'b0, "R5", "data in quiet window", int'(data_out), 0);
            end
            tick(1);
        end
        start_in = 1'b0;
        burst_clk_in = 1'b0;
        check(data_out == 1'b0, "R2", "data before original ready", int'(data_out), 0);
        tick(1);
        check(data_out == VB[DW-1], "R2", "MSB at original ready", int'(data_out), int'(VB[DW-1]));
        check(first_invalid_o == 1'b0, "R7", "second result valid", int'(first_invalid_o), 0);
        read_bits(VB, 0, DW, "R4");

        // R8: full read gives no loss, partial read gives loss
        sample_in = VC;
        pulse_start();
        tick(CLKL);
        check(data_lost_o == 1'b0, "R8", "lost after full read", int'(data_lost_o), 0);
        tick(MSB - CLKL);
        check(data_out == VC[DW-1], "R3", "MSB of C", int'(data_out), int'(VC[DW-1]));
        read_bits(VC, 0, 10, "R3");
        sample_in = VD;
        pulse_start();
        tick(CLKL - 1);
        check(data_lost_o == 1'b0, "R8", "lost held before clock-low", int'(data_lost_o), 0);
        tick(1);
        check(data_lost_o == 1'b1, "R8", "lost after partial read", int'(data_lost_o), 1);
        check(data_out == 1'b0, "R5", "data after clock-low", int'(data_out), 0);
        tick(MSB - CLKL);
        check(data_out == VD[DW-1], "R3", "MSB of D", int'(data_out), int'(VD[DW-1]));

        // R9: finish reading D while the next conversion runs
        read_bits(VD, 0, 4, "R3");
        sample_in = VE;
        pulse_start();
        read_bits(VD, 4, 12, "R9");
        tick(CLKL - 24);
        check(data_lost_o == 1'b0, "R9", "no loss when read during conversion", int'(data_lost_o), 0);
        tick(MSB - CLKL);
        check(data_out == VE[DW-1], "R1", "MSB of E", int'(data_out), int'(VE[DW-1]));
        read_bits(VE, 0, DW, "R3");
        tick(2);
        check(exp_q.size() == 0, "R4", "expected bits left unconsumed", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog run hung actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule